// File: doc/BRIEF.md
# Coherence Ring Hop

This block is one station of a one-way ring that moves cache-coherence requests between cores. Packets arrive from the upstream station on a valid/ready stream and leave toward the downstream station on a second valid/ready stream. Each packet carries a small hop counter. A station passes a packet on with the counter reduced by one. A packet that arrives with a counter of zero has gone all the way round: it is taken off the ring and shown on a last-hop output for one cycle.

The local core can place a new request on the ring: a read, an invalidate, or a read-with-invalidate. The request carries a tag, a set index and a 128-bit line. Traffic already on the ring always wins the output over a local request. While the local request cannot be taken, the block raises `out_stall`. The core keeps `send` and its fields steady until it sees an edge with `out_stall` low. The request is taken on that edge, exactly once.

Both streams follow the same back-pressure rule. A transfer happens on a rising edge where valid and ready are both high. A sender that has raised valid keeps valid and data steady until that transfer. `in_ready` is a combinational function of internal state and `out_ready`. Packet layout, from MSB down: hop count [159:156], read [155], invalidate [154], reply [153], tag [152:140], index [139:128], line [127:0].

Top module: `ring_hop`

## Requirements
- R1: On the edge where `send` is high and `out_stall` is low, the output slot is loaded. The loaded packet has hop count 3, read = `send_read`, invalidate = `send_inval`, reply = `set_reply`, and the tag, index and line taken from `core_tag`, `core_index` and `core_line`. `out_valid` is high after that edge.
- R2: A packet accepted from upstream with a hop count above zero is sent downstream with the hop count one lower and every other bit unchanged. It appears on the output the edge after it is accepted when the output slot is free.
- R3: A packet accepted with hop count zero is never sent downstream. On the next cycle, `last_hop_valid` is high for exactly one cycle and `last_hop_data` equals the accepted packet.
- R4: When a forwarded packet and a local request both wait for the output slot, the forwarded packet is loaded first.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold their values.
- R6: `in_ready` is low exactly when the forwarding register is full and the output slot cannot drain (`out_valid` high, `out_ready` low).
- R7: `out_stall` is high when the forwarding register is full, or when `out_valid` is high and `out_ready` is low. A local request held through a stall is sent once when the stall clears.
- R8: An edge with `rst_n` low clears the forwarding register, the output slot and the last-hop pulse. After it, `out_valid` = 0, `last_hop_valid` = 0, `in_ready` = 1 and `out_stall` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_data | input | 160 | Packet from the upstream station |
| in_valid | input | 1 | Upstream packet present |
| in_ready | output | 1 | Block can take an upstream packet |
| out_data | output | 160 | Packet toward the downstream station |
| out_valid | output | 1 | Downstream packet present |
| out_ready | input | 1 | Downstream station takes the packet |
| send | input | 1 | Local core requests injection |
| send_read | input | 1 | Local request sets the read flag |
| send_inval | input | 1 | Local request sets the invalidate flag |
| set_reply | input | 1 | Local request sets the reply flag |
| core_tag | input | 13 | Tag of the local request |
| core_index | input | 12 | Set index of the local request |
| core_line | input | 128 | Line data of the local request |
| out_stall | output | 1 | Local request cannot be taken this cycle |
| last_hop_data | output | 160 | Packet taken off the ring |
| last_hop_valid | output | 1 | One-cycle pulse for a packet taken off the ring |

## Verification
The assertions assume the upstream side keeps `in_valid` and `in_data` steady until accepted. They also assume the core keeps `send` and its fields steady until an edge with `out_stall` low. The directed stimulus honours both rules: it changes inputs only at falling edges. It drops `in_valid` or `send` only after the edge that accepted them. Downstream stalls come from holding `out_ready` low for several cycles while both a forwarded packet and a local request are pending.

// File: rtl/ring_hop_pkg.sv
package ring_hop_pkg;
  localparam int TTL_W  = 4;
  localparam int TAG_W  = 13;
  localparam int IDX_W  = 12;
  localparam int LINE_W = 128;
  localparam int FLAG_W = 3;
  localparam int PKT_W  = TTL_W + FLAG_W + TAG_W + IDX_W + LINE_W;

  typedef struct packed {
    logic [TTL_W-1:0]  hops;
    logic              rd;
    logic              inv;
    logic              rep;
    logic [TAG_W-1:0]  tag;
    logic [IDX_W-1:0]  idx;
    logic [LINE_W-1:0] line;
  } pkt_t;
endpackage

// File: rtl/ring_hop_fwd.sv
module ring_hop_fwd
  import ring_hop_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  pkt_t in_pkt,
  input  logic in_fire,
  input  logic drain,
  output pkt_t hold_pkt,
  output logic hold_full,
  output pkt_t lh_pkt,
  output logic lh_valid
);
  logic expired;
  pkt_t dec_pkt;

  // A hop count of zero means the packet has come all the way round.
  assign expired = (in_pkt.hops == '0);

  always_comb begin
    dec_pkt      = in_pkt;
    dec_pkt.hops = in_pkt.hops - TTL_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_pkt  <= '0;
      lh_pkt    <= '0;
      lh_valid  <= 1'b0;
    end else begin
      lh_valid <= in_fire && expired;
      if (in_fire && expired) lh_pkt <= in_pkt;
      if (in_fire && !expired) begin
        hold_pkt  <= dec_pkt;
        hold_full <= 1'b1;
      end else if (drain) begin
        hold_full <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ring_hop_inject.sv
module ring_hop_inject
  import ring_hop_pkg::*;
#(
  parameter int START_TTL = 3
) (
  input  logic              rd,
  input  logic              inv,
  input  logic              rep,
  input  logic [TAG_W-1:0]  tag,
  input  logic [IDX_W-1:0]  idx,
  input  logic [LINE_W-1:0] line,
  output pkt_t              pkt
);
  always_comb begin
    pkt.hops = TTL_W'(START_TTL);
    pkt.rd   = rd;
    pkt.inv  = inv;
    pkt.rep  = rep;
    pkt.tag  = tag;
    pkt.idx  = idx;
    pkt.line = line;
  end
endmodule

// File: rtl/ring_hop_out.sv
module ring_hop_out
  import ring_hop_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fwd_full,
  input  pkt_t fwd_pkt,
  input  logic loc_req,
  input  pkt_t loc_pkt,
  input  logic ready,
  output pkt_t pkt,
  output logic valid,
  output logic fwd_take,
  output logic stall
);
  logic slot_free;
  logic loc_take;

  assign slot_free = !valid || ready;
  assign fwd_take  = fwd_full && slot_free;
  assign loc_take  = loc_req && slot_free && !fwd_full;
  assign stall     = fwd_full || !slot_free;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      pkt   <= '0;
    end else if (fwd_take) begin
      pkt   <= fwd_pkt;
      valid <= 1'b1;
    end else if (loc_take) begin
      pkt   <= loc_pkt;
      valid <= 1'b1;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ring_hop.sv
module ring_hop
  import ring_hop_pkg::*;
#(
  parameter int START_TTL = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PKT_W-1:0]  in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [PKT_W-1:0]  out_data,
  output logic              out_valid,
  input  logic              out_ready,
  input  logic              send,
  input  logic              send_read,
  input  logic              send_inval,
  input  logic              set_reply,
  input  logic [TAG_W-1:0]  core_tag,
  input  logic [IDX_W-1:0]  core_index,
  input  logic [LINE_W-1:0] core_line,
  output logic              out_stall,
  output logic [PKT_W-1:0]  last_hop_data,
  output logic              last_hop_valid
);
  pkt_t fwd_pkt, loc_pkt, out_pkt, lh_pkt;
  logic fwd_full, fwd_take, in_fire;

  assign in_ready = !fwd_full || fwd_take;
  assign in_fire  = in_valid && in_ready;

  ring_hop_fwd u_fwd (
    .clk(clk), .rst_n(rst_n), .in_pkt(pkt_t'(in_data)), .in_fire(in_fire),
    .drain(fwd_take), .hold_pkt(fwd_pkt), .hold_full(fwd_full),
    .lh_pkt(lh_pkt), .lh_valid(last_hop_valid)
  );

  ring_hop_inject #(.START_TTL(START_TTL)) u_inj (
    .rd(send_read), .inv(send_inval), .rep(set_reply), .tag(core_tag),
    .idx(core_index), .line(core_line), .pkt(loc_pkt)
  );

  ring_hop_out u_out (
    .clk(clk), .rst_n(rst_n), .fwd_full(fwd_full), .fwd_pkt(fwd_pkt),
    .loc_req(send), .loc_pkt(loc_pkt), .ready(out_ready), .pkt(out_pkt),
    .valid(out_valid), .fwd_take(fwd_take), .stall(out_stall)
  );

  assign out_data      = out_pkt;
  assign last_hop_data = lh_pkt;
endmodule

// File: rtl/ring_hop_chk.sv
module ring_hop_chk
  import ring_hop_pkg::*;
#(
  parameter int START_TTL = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [PKT_W-1:0] in_data,
  input logic             in_valid,
  input logic             in_ready,
  input logic [PKT_W-1:0] out_data,
  input logic             out_valid,
  input logic             out_ready,
  input logic             send,
  input logic             send_read,
  input logic             send_inval,
  input logic             out_stall,
  input logic [PKT_W-1:0] last_hop_data,
  input logic             last_hop_valid,
  input logic             fwd_full
);
  localparam int HT = PKT_W - 1;
  localparam int HB = PKT_W - TTL_W;

  assert_local_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    send && !out_stall |=> out_valid && out_data[HT:HB] == TTL_W'(START_TTL)
      && out_data[HB-1] == $past(send_read) && out_data[HB-2] == $past(send_inval));

  assert_accept_fwd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_data[HT:HB] != '0 |=> fwd_full);

  assert_last_hop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_data[HT:HB] == '0
      |=> last_hop_valid && last_hop_data == $past(in_data));

  assert_out_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  assert_in_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> fwd_full && out_valid && !out_ready);

  assert_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_full |-> out_stall);
endmodule

bind ring_hop ring_hop_chk #(.START_TTL(START_TTL)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
  .in_ready(in_ready), .out_data(out_data), .out_valid(out_valid),
  .out_ready(out_ready), .send(send), .send_read(send_read),
  .send_inval(send_inval), .out_stall(out_stall),
  .last_hop_data(last_hop_data), .last_hop_valid(last_hop_valid),
  .fwd_full(fwd_full)
);

// File: tb/ring_hop_tb_top.sv
`timescale 1ns/100ps
module ring_hop_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [159:0] in_data = '0, out_data, last_hop_data;
  logic in_valid = 0, in_ready, out_valid, out_ready = 1, out_stall, last_hop_valid;
  logic send = 0, send_read = 0, send_inval = 0, set_reply = 0;
  logic [12:0] core_tag = '0;
  logic [11:0] core_index = '0;
  logic [127:0] core_line = '0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ring_hop dut_i (.*);

  function automatic logic [159:0] mk(logic [3:0] h, logic r, logic i, logic p,
      logic [12:0] t, logic [11:0] x, logic [127:0] l);
    return {h, r, i, p, t, x, l};
  endfunction

  task automatic step(); @(posedge clk); @(negedge clk); endtask

  task automatic chk(string req, logic [159:0] act, logic [159:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic local_req(logic r, logic i, logic p, logic [12:0] t,
      logic [11:0] x, logic [127:0] l);
    send = 1; send_read = r; send_inval = i; set_reply = p;
    core_tag = t; core_index = x; core_line = l;
  endtask

  task automatic t_reset();
    chk("R8 out_valid", out_valid, 0);
    chk("R8 last_hop_valid", last_hop_valid, 0);
    chk("R8 in_ready", in_ready, 1);
    chk("R8 out_stall", out_stall, 0);
  endtask

  task automatic t_local(logic r, logic i, logic p);
    logic [127:0] l = {4{32'hA5C3_0F00 ^ {29'd0, r, i, p}}};
    local_req(r, i, p, 13'h1ABC, 12'h5E7, l);
    step(); send = 0;
    chk("R1 out_valid", out_valid, 1);
    chk("R1 local packet", out_data, mk(4'd3, r, i, p, 13'h1ABC, 12'h5E7, l));
    step();
    chk("R1 drained", out_valid, 0);
  endtask

  task automatic t_forward();
    logic [159:0] p = mk(4'd2, 1, 0, 1, 13'h0F0F, 12'hABC, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210);
    in_data = p; in_valid = 1;
    step(); in_valid = 0;
    chk("R2 not yet out", out_valid, 0);
    step();
    chk("R2 out_valid", out_valid, 1);
    chk("R2 forwarded", out_data, {4'd1, p[155:0]});
    step();
    chk("R2 drained", out_valid, 0);
  endtask

  task automatic t_last_hop();
    logic [159:0] p = mk(4'd0, 0, 1, 1, 13'h1111, 12'h222, 128'hDEAD_BEEF);
    in_data = p; in_valid = 1;
    step(); in_valid = 0;
    chk("R3 pulse", last_hop_valid, 1);
    chk("R3 data", last_hop_data, p);
    step();
    chk("R3 pulse ends", last_hop_valid, 0);
    chk("R3 not forwarded", out_valid, 0);
  endtask

  task automatic t_priority();
    logic [159:0] a = mk(4'd3, 1, 0, 0, 13'h0AAA, 12'h0AA, 128'hAAAA);
    logic [159:0] f = mk(4'd3, 0, 1, 0, 13'h0FFF, 12'h0FF, 128'hFFFF);
    logic [159:0] b = mk(4'd3, 1, 1, 0, 13'h0BBB, 12'h0BB, 128'hBBBB);
    out_ready = 0;
    local_req(1, 0, 0, 13'h0AAA, 12'h0AA, 128'hAAAA);
    step();
    chk("R1 first load", out_data, a);
    local_req(1, 1, 0, 13'h0BBB, 12'h0BB, 128'hBBBB);
    in_data = f; in_valid = 1;
    chk("R7 stall on blocked output", out_stall, 1);
    step(); in_valid = 0;
    chk("R6 in_ready low", in_ready, 0);
    chk("R7 stall with full register", out_stall, 1);
    chk("R5 hold", out_data, a);
    out_ready = 1;
    #0.1;
    chk("R6 in_ready back", in_ready, 1);
    chk("R7 stall while register full", out_stall, 1);
    step();
    chk("R4 forwarded first", out_data, {4'd2, f[155:0]});
    out_ready = 0;
    step(); step();
    chk("R5 held valid", out_valid, 1);
    chk("R5 held data", out_data, {4'd2, f[155:0]});
    out_ready = 1;
    step(); send = 0;
    chk("R7 held request sent", out_data, b);
    step();
    chk("R7 no duplicate", out_valid, 0);
  endtask

  task automatic t_mid_reset();
    out_ready = 0;
    local_req(0, 1, 0, 13'h0002, 12'h003, 128'h4);
    step(); send = 0;
    chk("R8 setup loaded", out_valid, 1);
    rst_n = 0; step(); rst_n = 1;
    out_ready = 1;
    t_reset();
  endtask

  initial begin
    step(); step(); rst_n = 1; step();
    t_reset();
    t_local(1, 0, 0);
    t_local(0, 1, 0);
    t_local(1, 1, 1);
    t_forward();
    t_last_hop();
    t_priority();
    t_mid_reset();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule